// File: doc/BRIEF.md
# Edge Interrupt and Wakeup Detector

This block watches a bank of general-purpose input pins and turns their transitions into a single interrupt line and a separate wakeup request. Each pin passes through a synchroniser. A transition is found by comparing the synchronised value with the value it had one clock earlier. Each pin has four mask bits: rising-edge and falling-edge enables for the interrupt path, and a second rising/falling pair for the wake path. Any enabled edge sets that pin's bit in a status register. Software clears status bits by writing ones to a clear register.

While pin functions are being re-muxed, a force input closes the capture gate. Transitions caused by the switch then never reach the status register and cannot raise a false wakeup. The gate is a three-state machine:

- GATE_ARMED: capture is allowed. It moves to GATE_FORCED when force is high.
- GATE_FORCED: capture is blocked. It moves to GATE_DRAIN when force goes low.
- GATE_DRAIN: capture stays blocked for SYNC_STAGES-1 cycles. This lets transitions still in the synchroniser drain away. It returns to GATE_FORCED if force rises again, and otherwise to GATE_ARMED when its counter reaches zero.

The wake path needs the system sleep input to be high and the pin's sleep-control bit to be 0. The wake request stays asserted until software clears the pin's status bit.

Top module: `edge_wake_detector`

## Requirements
- R1: After reset, the register values are: rising-interrupt mask 0, falling-interrupt mask all ones, rising-wake mask 0, falling-wake mask all ones, sleep-control all ones, status 0. After reset, irq_o and wake_o are 0.
- R2: A pin transition from 0 to 1 (or from 1 to 0) with the matching interrupt mask bit set sets that pin's status bit. The bit is visible on the third rising clock edge after the pin changes. A transition whose mask bit is 0 sets nothing.
- R3: A pin held at a steady level never sets its status bit, whatever its masks.
- R4: Writing to the clear register (address 6) clears every status bit written as 1. Bits written as 0 keep their value.
- R5: If a new edge and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R6: irq_o is the OR over all pins of status AND (rising-interrupt mask OR falling-interrupt mask). It follows mask changes at once, even for bits that were latched by the wake path.
- R7: Edges from pin changes sampled while force_i is high are not latched, including those that reach the detector after force_i falls. A pin change in the cycle where force_i falls is latched.
- R8: If sleep_i is high, the pin's sleep-control bit is 0 and the pin's edge matches an enabled wake mask bit, then the status bit is set and wake_o rises. wake_o stays high, even after sleep_i falls, until that status bit is cleared.
- R9: A wake-mask edge does nothing while sleep_i is low, or while the pin's sleep-control bit is 1.
- R10: The register map is read and written through bus_addr as follows: 0 rising-interrupt mask, 1 falling-interrupt mask, 2 rising-wake mask, 3 falling-wake mask, 4 sleep-control. Address 5 is status and is read-only. Address 6 is the write-one-to-clear register and reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Asynchronous pin levels |
| force_i | input | 1 | Mux-switch window; blocks event capture |
| sleep_i | input | 1 | System sleep active; enables the wake path |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Combined edge interrupt |
| wake_o | output | 1 | Wakeup request |

## Verification
The sharpest corner is a clear write and a new edge landing on the same bit in the same cycle. A design where the clear wins would lose that event, and the bench reads the bit back as 0.

The force window is probed at both ends. A pin change one cycle before release must vanish; a design without the drain state would latch it. A pin change in the very cycle of release must be kept; a design with an overlong gate would drop it.

For the wake path, the bench checks that wake_o stays high after sleep ends. It also checks that a sleep-control bit of 1 or a low sleep input blocks the wake event entirely. A design that mixed up the polarity of the sleep-control bit would fail both checks.

// File: rtl/edge_wake_pkg.sv
package edge_wake_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_RISE_IRQ  = 3'd0;
    localparam logic [ADDR_W-1:0] REG_FALL_IRQ  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_RISE_WAKE = 3'd2;
    localparam logic [ADDR_W-1:0] REG_FALL_WAKE = 3'd3;
    localparam logic [ADDR_W-1:0] REG_SLEEP_CTL = 3'd4;
    localparam logic [ADDR_W-1:0] REG_STATUS    = 3'd5;
    localparam logic [ADDR_W-1:0] REG_CLEAR     = 3'd6;

    typedef enum logic [1:0] {
        GATE_ARMED  = 2'd0,
        GATE_FORCED = 2'd1,
        GATE_DRAIN  = 2'd2
    } gate_state_e;

endpackage

// File: rtl/ewd_pin_sync.sv
module ewd_pin_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_i,
    output logic [NPINS-1:0] rise_o,
    output logic [NPINS-1:0] fall_o
);
    logic [STAGES-1:0][NPINS-1:0] stage_q;
    logic [NPINS-1:0]             prev_q;
    logic [NPINS-1:0]             cur;

    assign cur = stage_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            prev_q  <= '0;
        end else begin
            stage_q[0] <= pins_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            prev_q <= cur;
        end
    end

    // Edge detection: the synchronised value against its value one clock earlier.
    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_edge
            assign rise_o[g] =  cur[g] & ~prev_q[g];
            assign fall_o[g] = ~cur[g] &  prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/ewd_gate_fsm.sv
module ewd_gate_fsm
    import edge_wake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_i,
    output logic capture_en_o
);
    localparam int DRAIN_CYCLES = SYNC_STAGES - 1;
    localparam int CNT_W        = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] DRAIN_LOAD = CNT_W'(DRAIN_CYCLES - 1);

    gate_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_ARMED:  if (force_i) state_d = GATE_FORCED;
            GATE_FORCED: if (!force_i) state_d = GATE_DRAIN;
            GATE_DRAIN: begin
                if (force_i)            state_d = GATE_FORCED;
                else if (cnt_q == '0)   state_d = GATE_ARMED;
            end
            default:                    state_d = GATE_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == GATE_FORCED)
                cnt_q <= DRAIN_LOAD;
            else if (state_q == GATE_DRAIN && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        capture_en_o = (state_q == GATE_ARMED);
    end

    // R7: release of force always passes through the drain state
    a_r7_release_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_FORCED && !force_i) |=> (state_q == GATE_DRAIN));

    // R7: a force seen while armed closes the gate next cycle
    a_r7_force_closes: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> !capture_en_o);

endmodule

// File: rtl/ewd_cfg_regs.sv
module ewd_cfg_regs
    import edge_wake_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic [NPINS-1:0]  status_i,
    output logic [NPINS-1:0]  bus_rdata,
    output logic [NPINS-1:0]  rise_irq_q,
    output logic [NPINS-1:0]  fall_irq_q,
    output logic [NPINS-1:0]  rise_wake_q,
    output logic [NPINS-1:0]  fall_wake_q,
    output logic [NPINS-1:0]  sleep_ctl_q,
    output logic [NPINS-1:0]  clr_mask_o
);
    localparam logic [NPINS-1:0] ALL_ONES = {NPINS{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_irq_q  <= '0;
            fall_irq_q  <= ALL_ONES;
            rise_wake_q <= '0;
            fall_wake_q <= ALL_ONES;
            sleep_ctl_q <= ALL_ONES;
        end else if (bus_we) begin
            case (bus_addr)
                REG_RISE_IRQ:  rise_irq_q  <= bus_wdata;
                REG_FALL_IRQ:  fall_irq_q  <= bus_wdata;
                REG_RISE_WAKE: rise_wake_q <= bus_wdata;
                REG_FALL_WAKE: fall_wake_q <= bus_wdata;
                REG_SLEEP_CTL: sleep_ctl_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign clr_mask_o = (bus_we && bus_addr == REG_CLEAR) ? bus_wdata : '0;

    always_comb begin
        case (bus_addr)
            REG_RISE_IRQ:  bus_rdata = rise_irq_q;
            REG_FALL_IRQ:  bus_rdata = fall_irq_q;
            REG_RISE_WAKE: bus_rdata = rise_wake_q;
            REG_FALL_WAKE: bus_rdata = fall_wake_q;
            REG_SLEEP_CTL: bus_rdata = sleep_ctl_q;
            REG_STATUS:    bus_rdata = status_i;
            default:       bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ewd_event_latch.sv
module ewd_event_latch #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] rise_i,
    input  logic [NPINS-1:0] fall_i,
    input  logic             capture_en_i,
    input  logic             sleep_i,
    input  logic [NPINS-1:0] rise_irq_i,
    input  logic [NPINS-1:0] fall_irq_i,
    input  logic [NPINS-1:0] rise_wake_i,
    input  logic [NPINS-1:0] fall_wake_i,
    input  logic [NPINS-1:0] sleep_ctl_i,
    input  logic [NPINS-1:0] clr_mask_i,
    output logic [NPINS-1:0] status_q,
    output logic [NPINS-1:0] wake_q
);
    logic [NPINS-1:0] set_vec, wake_set, status_d, wake_d;

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_pin
            logic irq_hit, wake_hit;
            assign irq_hit  = (rise_i[g] & rise_irq_i[g]) | (fall_i[g] & fall_irq_i[g]);
            // sleep-control 0 means wake detection enabled for this pin
            assign wake_hit = ((rise_i[g] & rise_wake_i[g]) | (fall_i[g] & fall_wake_i[g]))
                              & sleep_i & ~sleep_ctl_i[g];
            assign set_vec[g]  = capture_en_i & (irq_hit | wake_hit);
            assign wake_set[g] = capture_en_i & wake_hit;
            // a new event takes precedence over a clear in the same cycle
            assign status_d[g] = (status_q[g] & ~clr_mask_i[g]) | set_vec[g];
            assign wake_d[g]   = (wake_q[g]   & ~clr_mask_i[g]) | wake_set[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            wake_q   <= '0;
        end else begin
            status_q <= status_d;
            wake_q   <= wake_d;
        end
    end

    // R7: while the gate is closed no status bit may newly rise
    a_r7_no_capture_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en_i |=> ((status_q & ~$past(status_q)) == '0));

    // R4: cleared bits without a competing event read zero next cycle
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask_i & ~set_vec)) |=> ((status_q & $past(clr_mask_i & ~set_vec)) == '0));

    // R5: an event colliding with a clear leaves the bit set
    a_r5_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask_i & set_vec)) |=>
            ((status_q & $past(clr_mask_i & set_vec)) == $past(clr_mask_i & set_vec)));

    // R3: with no edge and no clear, status holds
    a_r3_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i == '0 && fall_i == '0 && clr_mask_i == '0) |=> $stable(status_q));

endmodule

// File: rtl/edge_wake_detector.sv
module edge_wake_detector
    import edge_wake_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_i,
    input  logic             force_i,
    input  logic             sleep_i,
    input  logic             bus_we,
    input  logic [2:0]       bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic             irq_o,
    output logic             wake_o
);
    logic [NPINS-1:0] rise, fall;
    logic [NPINS-1:0] rise_irq, fall_irq, rise_wake, fall_wake, sleep_ctl, clr_mask;
    logic [NPINS-1:0] status, wake_pend;
    logic             capture_en;

    ewd_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .rise_o(rise), .fall_o(fall)
    );

    ewd_gate_fsm #(.SYNC_STAGES(SYNC_STAGES)) gate_i (
        .clk(clk), .rst_n(rst_n), .force_i(force_i), .capture_en_o(capture_en)
    );

    ewd_cfg_regs #(.NPINS(NPINS)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .status_i(status), .bus_rdata(bus_rdata),
        .rise_irq_q(rise_irq), .fall_irq_q(fall_irq), .rise_wake_q(rise_wake),
        .fall_wake_q(fall_wake), .sleep_ctl_q(sleep_ctl), .clr_mask_o(clr_mask)
    );

    ewd_event_latch #(.NPINS(NPINS)) latch_i (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
        .capture_en_i(capture_en), .sleep_i(sleep_i),
        .rise_irq_i(rise_irq), .fall_irq_i(fall_irq),
        .rise_wake_i(rise_wake), .fall_wake_i(fall_wake),
        .sleep_ctl_i(sleep_ctl), .clr_mask_i(clr_mask),
        .status_q(status), .wake_q(wake_pend)
    );

    always_comb begin
        irq_o  = |(status & (rise_irq | fall_irq));
        wake_o = |wake_pend;
    end

    // R8: a wake request can only start after a cycle with sleep active
    a_r8_wake_needs_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(sleep_i));

    // R6: no interrupt without a latched status bit
    a_r6_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq_o);

endmodule

// File: tb/edge_wake_detector_tb_top.sv
`timescale 1ns/1ps
module edge_wake_detector_tb_top;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pins_i;
    logic          force_i, sleep_i, bus_we;
    logic [2:0]    bus_addr;
    logic [NP-1:0] bus_wdata, bus_rdata;
    logic          irq_o, wake_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    edge_wake_detector #(.NPINS(NP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .force_i(force_i),
        .sleep_i(sleep_i), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
    );

    // {rise_irq, fall_irq, pins_before, pins_after}
    localparam logic [127:0] VEC [8] = '{
        {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hA5A5_A5A5},
        {32'h0000_FFFF, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_F0F0},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8765_4321},
        {32'h8000_0001, 32'h0000_0000, 32'h0000_0000, 32'h8000_0001},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NP-1:0] v, r, f, b, a, exp;
        rst_n = 1'b0; pins_i = '0; force_i = 1'b0; sleep_i = 1'b0;
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(3'd0, v); chk("R1 rise_irq", v, 32'h0);
        rd(3'd1, v); chk("R1 fall_irq", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R1 rise_wake", v, 32'h0);
        rd(3'd3, v); chk("R1 fall_wake", v, 32'hFFFF_FFFF);
        rd(3'd4, v); chk("R1 sleep_ctl", v, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R1 status", v, 32'h0);
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 wake_o", {31'd0, wake_o}, 32'd0);

        // R10 register map read-back
        wr(3'd2, 32'h0F0F_1234); rd(3'd2, v); chk("R10 rise_wake rw", v, 32'h0F0F_1234);
        wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); chk("R10 clear reads 0", v, 32'h0);
        wr(3'd2, 32'h0);

        // R2 R3 R6 vector table
        for (int i = 0; i < 8; i++) begin
            {r, f, b, a} = VEC[i];
            wr(3'd0, r); wr(3'd1, f);
            pins_i = b; settle();
            wr(3'd6, 32'hFFFF_FFFF);
            pins_i = a; settle();
            exp = (~b & a & r) | (b & ~a & f);
            rd(3'd5, v); chk($sformatf("R2 R3 vector %0d status", i), v, exp);
            chk($sformatf("R6 vector %0d irq", i), {31'd0, irq_o}, {31'd0, |exp});
        end

        // R4 partial clear
        wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        pins_i = 32'h0000_00FF; settle();
        rd(3'd5, v); chk("R2 eight rises", v, 32'h0000_00FF);
        wr(3'd6, 32'h0000_000F);
        rd(3'd5, v); chk("R4 partial clear", v, 32'h0000_00F0);

        // R5 edge wins over clear in same cycle
        wr(3'd6, 32'hFFFF_FFFF);
        pins_i = 32'h0000_00FE; settle();
        rd(3'd5, v); chk("R5 setup fall", v, 32'h1);
        @(negedge clk); pins_i = 32'h0000_00FF;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h1;
        @(negedge clk); bus_we = 1'b0;
        rd(3'd5, v); chk("R5 edge beats clear", v, 32'h1);
        wr(3'd6, 32'h1);
        rd(3'd5, v); chk("R4 plain clear", v, 32'h0);

        // R7 force window
        @(negedge clk); force_i = 1'b1; pins_i = 32'h0;
        repeat (3) @(negedge clk);
        pins_i = 32'h0F; repeat (3) @(negedge clk);
        pins_i = 32'h1F;
        @(negedge clk); force_i = 1'b0;
        settle();
        rd(3'd5, v); chk("R7 edges under force dropped", v, 32'h0);
        @(negedge clk); force_i = 1'b1;
        repeat (3) @(negedge clk);
        force_i = 1'b0; pins_i = 32'h3F;
        settle();
        rd(3'd5, v); chk("R7 edge at release kept", v, 32'h20);

        // R8 R9 wake path
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0); wr(3'd1, 32'h0);
        wr(3'd4, 32'hFFFF_FFFE);
        sleep_i = 1'b1;
        pins_i = 32'h3E; settle();
        rd(3'd5, v); chk("R8 wake status", v, 32'h1);
        chk("R8 wake_o", {31'd0, wake_o}, 32'd1);
        chk("R6 irq masked off", {31'd0, irq_o}, 32'd0);
        sleep_i = 1'b0; settle();
        chk("R8 wake holds", {31'd0, wake_o}, 32'd1);
        wr(3'd6, 32'h1);
        chk("R8 wake clears", {31'd0, wake_o}, 32'd0);
        sleep_i = 1'b1;
        pins_i = 32'h3C; settle();
        rd(3'd5, v); chk("R9 sleep_ctl 1 blocks", v, 32'h0);
        chk("R9 wake_o blocked", {31'd0, wake_o}, 32'd0);
        wr(3'd4, 32'hFFFF_FFFA);
        sleep_i = 1'b0;
        pins_i = 32'h38; settle();
        rd(3'd5, v); chk("R9 no sleep blocks", v, 32'h0);
        chk("R9 wake_o idle", {31'd0, wake_o}, 32'd0);

        // R6 irq follows mask over a wake-latched bit
        wr(3'd2, 32'h1);
        sleep_i = 1'b1;
        pins_i = 32'h39; settle();
        rd(3'd5, v); chk("R8 rising wake", v, 32'h1);
        chk("R6 irq before mask", {31'd0, irq_o}, 32'd0);
        wr(3'd0, 32'h1);
        #1 chk("R6 irq after mask", {31'd0, irq_o}, 32'd1);
        sleep_i = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule